// File: doc/BRIEF.md
# Strobe-Decoded DRAM Cycle Model

This block is a clocked behavioural stand-in for an asynchronous page-mode DRAM. It is used as the target when memory controllers are tested. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable), the multiplexed address pins and the write data. The block then works out the cycle type from the order in which the strobe edges arrive. The supported cycles are:

- read
- early write
- late write
- read-modify-write
- row-only refresh
- column-before-row refresh
- hidden refresh

Row and column addresses are latched on their strobes. The array holds bytes. A 10-bit internal counter supplies refresh rows. The block decides when the data outputs are driven.

The array stores only a power-of-two subset of the rows, so the model stays small in simulation. Only the low row bits select an array row, and rows that differ only in the upper bits alias onto the same storage. Two debug outputs support self-checking:

- a code that names the most recently decoded cycle;
- the number of the row that was last refreshed.

Pins are registered once at the clock, and a strobe edge is found by comparing two successive samples. Every output therefore reacts on the second rising clock edge after a pin changes. Analog timing (setup, hold, minimum pulse widths) is not checked.

Top module: `dram_cycle_model`

## Requirements
- R1: A row-strobe fall while the column strobe is high starts an access cycle. It latches the row from `addr`, loads that row into `rfsh_row`, sets `cyc_type` to 5 (row-only) and leaves `dout_en` low.
- R2: A row-strobe fall while the column strobe is already low is a column-before-row refresh, unless the outputs are being driven at that moment (R8 covers that case). `rfsh_row` takes the internal counter, the counter then steps by one and wraps from 1023 to 0, `addr` is ignored, `cyc_type` becomes 6 and `dout_en` stays low.
- R3: A read starts on whichever comes later of the column-strobe fall and the output-enable fall, provided write enable is high. `dout_en` goes high with `dout` equal to the addressed byte, and `cyc_type` becomes 1.
- R4: Write enable low at the column-strobe fall is an early write. `din` is stored at the addressed byte, `cyc_type` becomes 2, and `dout_en` stays low for the rest of the cycle.
- R5: A write-enable fall after the column-strobe fall stores `din`. If no data was driven in that column cycle, it is a late write and `cyc_type` becomes 3.
- R6: A write-enable fall after read data was driven in the same column cycle is a read-modify-write. `cyc_type` becomes 4, and a later output-enable fall with the column strobe still low returns the new byte.
- R7: `dout_en` falls when output enable rises, when the column strobe rises, or when both the row and column strobes are high.
- R8: A row-strobe toggle while the column strobe stays low after a read is a hidden refresh. `cyc_type` becomes 7, `dout` and `dout_en` keep the read data, and the refresh counter supplies `rfsh_row` and steps by one.
- R9: Several column cycles under one low row strobe (page mode) each latch a new column and access it.
- R10: Only the low `MAP_ROW_W` bits of the row (default 2) select the array row. Rows that differ only above those bits reach the same bytes.
- R11: After reset, `dout_en` is 0, `cyc_type` is 0, `rfsh_row` is 0 and the refresh counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W (10) | Multiplexed row/column address |
| din | input | DATA_W (8) | Write data |
| dout | output | DATA_W (8) | Read data, valid while dout_en is high |
| dout_en | output | 1 | Output drive enable (low means high-impedance) |
| cyc_type | output | 3 | Last decoded cycle code |
| rfsh_row | output | ROW_W (10) | Row most recently refreshed |

## Verification
If the latched row or column is wrong, a later read that re-addresses the written location returns the wrong `dout` two clocks after its strobe edge. An aliasing read through an upper-row address exposes a wrong row mapping in the same way. If the cycle classification is wrong, `cyc_type` shows it, or `dout_en` is driven during an early write or a refresh, two clocks after the deciding edge. If the refresh counter has slipped, `rfsh_row` shows it on the very next refresh, including the wrap after 1024 steps.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;
  typedef enum logic [2:0] {
    CY_IDLE   = 3'd0,
    CY_READ   = 3'd1,
    CY_EWR    = 3'd2,
    CY_LWR    = 3'd3,
    CY_RMW    = 3'd4,
    CY_RONLY  = 3'd5,
    CY_CBR    = 3'd6,
    CY_HIDDEN = 3'd7
  } cyc_e;

  localparam int unsigned STROBE_N = 4;
  localparam int unsigned S_RAS = 0;
  localparam int unsigned S_CAS = 1;
  localparam int unsigned S_WE  = 2;
  localparam int unsigned S_OE  = 3;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  // Two sample stages per strobe; idle (high) after reset so no edge is invented.
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s_q, p_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= 1'b1;
        p_q <= 1'b1;
      end else begin
        s_q <= pins[i];
        p_q <= s_q;
      end
    end
    assign lvl[i] = s_q;
    assign prv[i] = p_q;
  end
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
  import dram_model_pkg::*;
#(
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned MAP_ROW_W = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [2:0]        cyc_type,
  output logic [ROW_W-1:0]  rfsh_row
);
  localparam int unsigned MEM_AW = MAP_ROW_W + COL_W;

  logic [STROBE_N-1:0] lvl, prv;
  logic [ROW_W-1:0]    addr_s;
  logic [DATA_W-1:0]   din_s;

  strobe_sampler #(.N(STROBE_N)) u_smp (
    .clk(clk), .rst(rst),
    .pins({oe_n, we_n, cas_n, ras_n}),
    .lvl(lvl), .prv(prv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      addr_s <= addr;
      din_s  <= din;
    end
  end

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_fall, oe_rise;
  assign ras_fall = prv[S_RAS] & ~lvl[S_RAS];
  assign ras_rise = ~prv[S_RAS] & lvl[S_RAS];
  assign cas_fall = prv[S_CAS] & ~lvl[S_CAS];
  assign cas_rise = ~prv[S_CAS] & lvl[S_CAS];
  assign we_fall  = prv[S_WE] & ~lvl[S_WE];
  assign oe_fall  = prv[S_OE] & ~lvl[S_OE];
  assign oe_rise  = ~prv[S_OE] & lvl[S_OE];

  logic                 acc_q, col_ok_q, drv_q, en_q;
  logic [MAP_ROW_W-1:0] row_q;
  logic [COL_W-1:0]     col_q;
  cyc_e                 cyc_q;
  logic [ROW_W-1:0]     rr_q;
  logic [ROW_W-1:0]     cnt;

  logic cbr_ev, acc_ev, cas_ev, ew_ev, rd_ev, wl_ev, off_ev;
  logic [COL_W-1:0]  col_now;
  logic [MEM_AW-1:0] mem_a;
  logic [DATA_W-1:0] rdata;

  always_comb begin
    cbr_ev  = ras_fall & ~lvl[S_CAS];
    acc_ev  = ras_fall & lvl[S_CAS];
    cas_ev  = acc_q & cas_fall;
    col_now = cas_ev ? addr_s[COL_W-1:0] : col_q;
    ew_ev   = cas_ev & ~lvl[S_WE];
    rd_ev   = (cas_ev & lvl[S_WE] & ~lvl[S_OE])
            | (col_ok_q & ~lvl[S_CAS] & oe_fall & lvl[S_WE]);
    wl_ev   = col_ok_q & ~lvl[S_CAS] & we_fall;
    off_ev  = oe_rise | cas_rise | (lvl[S_RAS] & lvl[S_CAS])
            | ew_ev | wl_ev | (cbr_ev & ~en_q);
    mem_a   = {row_q, col_now};
  end

  refresh_counter #(.W(ROW_W)) u_rc (
    .clk(clk), .rst(rst), .inc(cbr_ev), .cnt(cnt)
  );

  byte_array #(.AW(MEM_AW), .DW(DATA_W)) u_arr (
    .clk(clk), .we(ew_ev | wl_ev), .waddr(mem_a), .wdata(din_s),
    .raddr(mem_a), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= 1'b0;
      col_ok_q <= 1'b0;
      drv_q    <= 1'b0;
      en_q     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      cyc_q    <= CY_IDLE;
      rr_q     <= '0;
    end else begin
      if (acc_ev) begin
        acc_q <= 1'b1;
        row_q <= addr_s[MAP_ROW_W-1:0];
        rr_q  <= addr_s;
        cyc_q <= CY_RONLY;
      end
      if (ras_rise) begin
        acc_q    <= 1'b0;
        col_ok_q <= 1'b0;
      end
      if (cbr_ev) begin
        rr_q  <= cnt;
        cyc_q <= en_q ? CY_HIDDEN : CY_CBR;
      end
      if (cas_ev) begin
        col_q    <= addr_s[COL_W-1:0];
        col_ok_q <= 1'b1;
        drv_q    <= 1'b0;
        cyc_q    <= lvl[S_WE] ? CY_READ : CY_EWR;
      end
      if (cas_rise) col_ok_q <= 1'b0;
      if (rd_ev) begin
        drv_q <= 1'b1;
        cyc_q <= CY_READ;
      end
      if (wl_ev) cyc_q <= drv_q ? CY_RMW : CY_LWR;
      if (rd_ev)       en_q <= 1'b1;
      else if (off_ev) en_q <= 1'b0;
    end
  end

  assign dout     = rdata;
  assign dout_en  = en_q;
  assign cyc_type = cyc_q;
  assign rfsh_row = rr_q;

  // R2
  cbr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cbr_ev && !en_q) |=> !dout_en);
  // R2
  cbr_row_chk: assert property (@(posedge clk) disable iff (rst)
    cbr_ev |=> rfsh_row == $past(cnt));
  // R4
  early_off_chk: assert property (@(posedge clk) disable iff (rst)
    ew_ev |=> (!dout_en && cyc_type == CY_EWR));
  // R7
  cas_off_chk: assert property (@(posedge clk) disable iff (rst)
    cas_rise |=> !dout_en);
  // R8
  hidden_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cbr_ev && en_q) |=> (dout_en && $stable(dout)));
endmodule

// File: tb/dram_cycle_model_test.sv
module dram_cycle_model_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic [2:0] cyc_type;
  logic [9:0] rfsh_row;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_cycle_model uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .cyc_type(cyc_type), .rfsh_row(rfsh_row)
  );

  // {ras,cas,we,oe}, addr, din, exp_en, exp_dout, exp_type
  localparam int NV = 27;
  localparam logic [33:0] VEC [NV] = '{
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd0},
    {4'b0111, 10'd5, 8'h00, 1'b0, 8'h00, 3'd5},
    {4'b0101, 10'd3, 8'hA5, 1'b0, 8'h00, 3'd5},
    {4'b0001, 10'd3, 8'hA5, 1'b0, 8'h00, 3'd2},
    {4'b0111, 10'd3, 8'hA5, 1'b0, 8'h00, 3'd2},
    {4'b0001, 10'd4, 8'h3C, 1'b0, 8'h00, 3'd2},
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd2},
    {4'b0110, 10'd5, 8'h00, 1'b0, 8'h00, 3'd5},
    {4'b0010, 10'd3, 8'h00, 1'b1, 8'hA5, 3'd1},
    {4'b0011, 10'd3, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0010, 10'd3, 8'h00, 1'b1, 8'hA5, 3'd1},
    {4'b0110, 10'd3, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0010, 10'd4, 8'h00, 1'b1, 8'h3C, 3'd1},
    {4'b0011, 10'd4, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0001, 10'd4, 8'h77, 1'b0, 8'h00, 3'd4},
    {4'b0010, 10'd4, 8'h77, 1'b1, 8'h77, 3'd1},
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0111, 10'd6, 8'h00, 1'b0, 8'h00, 3'd5},
    {4'b0011, 10'd1, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0001, 10'd1, 8'h99, 1'b0, 8'h00, 3'd3},
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd3},
    {4'b0110, 10'd6, 8'h00, 1'b0, 8'h00, 3'd5},
    {4'b0010, 10'd1, 8'h00, 1'b1, 8'h99, 3'd1},
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd1},
    {4'b0110, 10'd9, 8'h00, 1'b0, 8'h00, 3'd5},
    {4'b0010, 10'd3, 8'h00, 1'b1, 8'hA5, 3'd1},
    {4'b1111, 10'd0, 8'h00, 1'b0, 8'h00, 3'd1}
  };

  function automatic string tag_of(int i);
    case (i)
      0:               return "R11";
      1:               return "R1";
      5:               return "R9";
      2, 3, 4, 6:      return "R4";
      9, 11, 16, 26:   return "R7";
      12:              return "R9";
      7, 8, 10:        return "R3";
      13, 14, 15:      return "R6";
      17, 18, 19, 20:  return "R5";
      24, 25:          return "R10";
      default:         return "R3";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] p, logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    {ras_n, cas_n, we_n, oe_n} = p;
    addr = a;
    din  = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11", "dout_en", int'(dout_en), 0);
    check("R11", "cyc_type", int'(cyc_type), 0);
    check("R11", "rfsh_row", int'(rfsh_row), 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      apply(v[33:30], v[29:20], v[19:12]);
      check(tag_of(i), "dout_en", int'(dout_en), int'(v[11]));
      if (v[11]) check(tag_of(i), "dout", int'(dout), int'(v[10:3]));
      check(tag_of(i), "cyc_type", int'(cyc_type), int'(v[2:0]));
    end

    // R1 row-only refresh reports the pin row
    apply(4'b0111, 10'h155, 8'h00);
    check("R1", "rfsh_row", int'(rfsh_row), 'h155);
    check("R1", "dout_en", int'(dout_en), 0);
    apply(4'b1111, 10'h0, 8'h00);

    // R2 refresh with column strobe first; address pins ignored
    apply(4'b1011, 10'h3FF, 8'h00);
    apply(4'b0011, 10'h3FF, 8'h00);
    check("R2", "rfsh_row", int'(rfsh_row), 0);
    check("R2", "cyc_type", int'(cyc_type), 6);
    check("R2", "dout_en", int'(dout_en), 0);
    apply(4'b1111, 10'h0, 8'h00);
    apply(4'b1011, 10'h200, 8'h00);
    apply(4'b0011, 10'h200, 8'h00);
    check("R2", "rfsh_row second", int'(rfsh_row), 1);
    apply(4'b1111, 10'h0, 8'h00);

    // R8 hidden refresh after a read of row 5 column 3
    apply(4'b0110, 10'd5, 8'h00);
    apply(4'b0010, 10'd3, 8'h00);
    check("R8", "read dout", int'(dout), 'hA5);
    apply(4'b1010, 10'd3, 8'h00);
    check("R8", "held across row rise", int'(dout_en), 1);
    apply(4'b0010, 10'h2AA, 8'h00);
    check("R8", "cyc_type", int'(cyc_type), 7);
    check("R8", "dout_en", int'(dout_en), 1);
    check("R8", "dout", int'(dout), 'hA5);
    check("R8", "rfsh_row", int'(rfsh_row), 2);
    apply(4'b1111, 10'h0, 8'h00);
    check("R7", "dout_en off", int'(dout_en), 0);

    // R2 counter wrap: rows 3..1023 then 0
    for (int k = 0; k < 1021; k++) begin
      apply(4'b1011, 10'h0, 8'h00);
      apply(4'b0011, 10'h0, 8'h00);
      apply(4'b1111, 10'h0, 8'h00);
    end
    check("R2", "rfsh_row top", int'(rfsh_row), 1023);
    apply(4'b1011, 10'h0, 8'h00);
    apply(4'b0011, 10'h0, 8'h00);
    check("R2", "rfsh_row wrap", int'(rfsh_row), 0);
    apply(4'b1111, 10'h0, 8'h00);

    finish_run();
  end
endmodule